// File: doc/BRIEF.md
# Half-Step Delayed Pulse Generator

This block holds a bank of independent one-shot channels. On each channel a trigger starts a programmable delay. When the delay ends, the channel drives an output pulse of programmable width. Every interval is counted in core clock cycles. The block still places each pulse edge to half a clock period, because it tracks which half of the cycle the trigger fell in.

The trigger arrives on each channel as a pair of per-cycle bits, one for each clock phase. The output leaves as a matching pair, which a double-data-rate output register can drive. Delay and width presets live in a small register bank that is written through an address/data/strobe port. Each trigger takes a copy of the presets of its channel, so a write never disturbs a pulse already under way. A channel is deaf to triggers from the moment it accepts one until its pulse has ended.

Top module: `halfstep_pulse_gen`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, every output bit is 0, even with triggers applied.
- R2: Trigger and output pairs use bit 0 for the first half of a cycle and bit 1 for the second half. A trigger on bit 0 alone is accepted at edge e0. It yields output 2'b11 after edges eD through eD+W-1, and 2'b00 otherwise. D and W are the delay and width presets.
- R3: A trigger on bit 1 alone keeps its half-cycle phase. The output is 2'b10 after edge eD, then 2'b11 after eD+1 through eD+W-1, then 2'b01 after eD+W. The pulse therefore lasts exactly 2W half-cycles.
- R4: When both trigger bits are set in one cycle, the first half wins and the pulse follows R2.
- R5: A preset of 0 acts as 1, for both delay and width.
- R6: A trigger that arrives while the channel is delaying or pulsing is ignored. This includes the last pulse cycle and the trailing half-cycle of a late pulse. A trigger in the first idle cycle after the pulse is accepted.
- R7: A preset write during a pulse leaves that pulse unchanged. The next trigger on that channel uses the new value.
- R8: The write address has two parts. Bit 0 selects the field: 0 for delay, 1 for width. The upper bits select the channel. Output pair c sits on bits 2c+1:2c and only reacts to trigger pair c.
- R9: The full 13-bit preset 8191 gives a delay or a width of exactly 8191 cycles.
- R10: A late-phase leading pair 2'b10 is always followed by a cycle with bit 0 high. A trailing pair 2'b01 is always followed by 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Preset write strobe |
| wr_addr | input | ADDR_W (4) | {channel, field}, field 0 = delay, 1 = width |
| wr_data | input | CNT_W (13) | Preset value |
| trig_i | input | 2*NCH (16) | Per-channel trigger pair, bit 0 = first half |
| pulse_o | output | 2*NCH (16) | Per-channel output pair, bit 0 = first half |

## Verification
The bench checks the half-cycle phase at both ends of the pulse. A design that dropped the phase would show 2'b11 where 2'b10 belongs, and would end a late pulse half a cycle early by never emitting 2'b01. It places triggers in the last pulse cycle and in the trailing half-cycle. A design that rearmed too early would start a second pulse there, and a design that rearmed too late would miss the trigger in the first idle cycle. Zero presets show up as a stall or a wrapped count if a design counts them literally. A width write during a pulse shows up as a shortened or stretched pulse if the design reads the live register instead of its snapshot.

// File: rtl/halfstep_pulse_pkg.sv
package halfstep_pulse_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_DRIVE = 2'd2,
        ST_TAIL  = 2'd3
    } shot_state_e;

    typedef enum logic {
        HALF_EARLY = 1'b0,
        HALF_LATE  = 1'b1
    } half_e;

    typedef struct packed {
        logic  hit;
        half_e half;
    } edge_cap_t;

    // First-half bit has priority when both halves saw the trigger.
    function automatic edge_cap_t pick_half(input logic [1:0] t);
        edge_cap_t r;
        r.hit  = |t;
        r.half = t[0] ? HALF_EARLY : HALF_LATE;
        return r;
    endfunction

    // Output pair for a given state.
    function automatic logic [1:0] drive_pair(input shot_state_e st,
                                              input half_e       h,
                                              input logic        first);
        logic [1:0] r;
        case (st)
            ST_DRIVE: r = (h == HALF_LATE && first) ? 2'b10 : 2'b11;
            ST_TAIL:  r = 2'b01;
            default:  r = 2'b00;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/halfstep_preset_bank.sv
module halfstep_preset_bank #(
    parameter int NCH    = 8,
    parameter int CNT_W  = 13,
    parameter int ADDR_W = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [CNT_W-1:0]       wr_data,
    output logic [NCH*CNT_W-1:0]   dly_o,
    output logic [NCH*CNT_W-1:0]   wid_o
);
    localparam int SEL_W = ADDR_W - 1;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic hit_c;
        logic [CNT_W-1:0] dly_q, wid_q;

        assign hit_c = wr_en && (wr_addr[ADDR_W-1:1] == SEL_W'(c));

        always_ff @(posedge clk) begin
            if (rst) begin
                dly_q <= '0;
                wid_q <= '0;
            end else if (hit_c) begin
                if (wr_addr[0]) wid_q <= wr_data;
                else            dly_q <= wr_data;
            end
        end

        assign dly_o[c*CNT_W +: CNT_W] = dly_q;
        assign wid_o[c*CNT_W +: CNT_W] = wid_q;
    end

endmodule

// File: rtl/halfstep_oneshot_chan.sv
module halfstep_oneshot_chan
    import halfstep_pulse_pkg::*;
#(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       trig,
    input  logic [CNT_W-1:0] dly_preset,
    input  logic [CNT_W-1:0] wid_preset,
    output logic [1:0]       pulse
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
        return (v == '0) ? ONE : v;
    endfunction

    shot_state_e      st_q;
    half_e            half_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] wid_snap_q;
    logic             first_q;
    edge_cap_t        cap;

    assign cap = pick_half(trig);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            half_q     <= HALF_EARLY;
            cnt_q      <= '0;
            wid_snap_q <= '0;
            first_q    <= 1'b0;
        end else begin
            first_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (cap.hit) begin
                        st_q       <= ST_WAIT;
                        half_q     <= cap.half;
                        cnt_q      <= at_least_one(dly_preset);
                        wid_snap_q <= at_least_one(wid_preset);
                    end
                end
                ST_WAIT: begin
                    if (cnt_q == ONE) begin
                        st_q    <= ST_DRIVE;
                        cnt_q   <= wid_snap_q;
                        first_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - ONE;
                    end
                end
                ST_DRIVE: begin
                    if (cnt_q == ONE) begin
                        st_q <= (half_q == HALF_LATE) ? ST_TAIL : ST_IDLE;
                    end else begin
                        cnt_q <= cnt_q - ONE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign pulse = drive_pair(st_q, half_q, first_q);

endmodule

// File: rtl/halfstep_pulse_gen.sv
module halfstep_pulse_gen #(
    parameter  int NCH    = 8,
    parameter  int CNT_W  = 13,
    localparam int ADDR_W = $clog2(NCH) + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [CNT_W-1:0]    wr_data,
    input  logic [2*NCH-1:0]    trig_i,
    output logic [2*NCH-1:0]    pulse_o
);
    logic [NCH*CNT_W-1:0] dly_all;
    logic [NCH*CNT_W-1:0] wid_all;

    halfstep_preset_bank #(
        .NCH    (NCH),
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .dly_o   (dly_all),
        .wid_o   (wid_all)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        halfstep_oneshot_chan #(.CNT_W(CNT_W)) u_shot (
            .clk        (clk),
            .rst        (rst),
            .trig       (trig_i[2*c +: 2]),
            .dly_preset (dly_all[c*CNT_W +: CNT_W]),
            .wid_preset (wid_all[c*CNT_W +: CNT_W]),
            .pulse      (pulse_o[2*c +: 2])
        );
    end

endmodule

// File: rtl/halfstep_pulse_gen_chk.sv
module halfstep_pulse_gen_chk #(
    parameter int NCH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [2*NCH-1:0] pulse_o
);
    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    // R1: the cycle after a reset edge shows no output.
    always @(negedge clk) begin
        if (rst_d === 1'b1) begin
            a_r1_quiet_after_reset: assert (pulse_o == '0)
                else $error("R1 output active after reset");
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        // R10 / R3: a late leading half is followed by a first half high.
        a_r10_late_lead_continues: assert property (@(posedge clk) disable iff (rst)
            (pulse_o[2*c +: 2] == 2'b10) |=> pulse_o[2*c]);
        // R10 / R3: the trailing half-cycle closes the pulse.
        a_r10_tail_closes: assert property (@(posedge clk) disable iff (rst)
            (pulse_o[2*c +: 2] == 2'b01) |=> (pulse_o[2*c +: 2] == 2'b00));
        // R6: no new pulse can start straight out of a full-cycle high.
        a_r6_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
            (pulse_o[2*c +: 2] == 2'b11) |=> (pulse_o[2*c +: 2] != 2'b10));
        // R3: a late leading half never repeats in the next cycle.
        a_r3_single_lead: assert property (@(posedge clk) disable iff (rst)
            (pulse_o[2*c +: 2] == 2'b10) |=> (pulse_o[2*c +: 2] != 2'b10));
    end

endmodule

bind halfstep_pulse_gen halfstep_pulse_gen_chk #(.NCH(NCH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .pulse_o (pulse_o)
);

// File: tb/halfstep_pulse_gen_test.sv
`timescale 1ns/1ps
module halfstep_pulse_gen_test;
    localparam int NCH    = 8;
    localparam int CNT_W  = 13;
    localparam int ADDR_W = $clog2(NCH) + 1;
    localparam int NVEC   = 8;

    // vector table: channel, trigger pair, delay preset, width preset
    localparam int         V_CH [NVEC] = '{0, 1, 2, 3, 4, 5, 6, 7};
    localparam logic [1:0] V_TR [NVEC] = '{2'b01, 2'b10, 2'b11, 2'b10, 2'b01, 2'b10, 2'b01, 2'b10};
    localparam int         V_D  [NVEC] = '{3, 3, 2, 1, 0, 0, 7, 5};
    localparam int         V_W  [NVEC] = '{4, 4, 2, 1, 0, 5, 1, 0};

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                wr_en = 1'b0;
    logic [ADDR_W-1:0]   wr_addr = '0;
    logic [CNT_W-1:0]    wr_data = '0;
    logic [2*NCH-1:0]    trig_i = '0;
    logic [2*NCH-1:0]    pulse_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    halfstep_pulse_gen #(.NCH(NCH), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .trig_i(trig_i), .pulse_o(pulse_o)
    );

    function automatic string vec_tag(input int i);
        case (i)
            0: return "R2/R8";
            1: return "R3/R8";
            2: return "R4/R8";
            3: return "R3/R8";
            4: return "R5/R8";
            5: return "R5/R3";
            6: return "R2/R8";
            default: return "R5/R3";
        endcase
    endfunction

    // expected pair after edge j counted from the accepting edge e0
    function automatic logic [1:0] exp_pair(input int j, input int d, input int w, input bit late);
        if (j < d)          return 2'b00;
        if (j == d)         return late ? 2'b10 : 2'b11;
        if (j < d + w)      return 2'b11;
        if (j == d + w)     return late ? 2'b01 : 2'b00;
        return 2'b00;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [2*NCH-1:0] got,
                         input logic [2*NCH-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic write_reg(input int ch, input bit field, input int val);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = ADDR_W'(ch * 2 + int'(field));
        wr_data = CNT_W'(val);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_case(input int ch, input logic [1:0] tb, input int d, input int w,
                            input bit prog, input int inj_j, input logic [1:0] inj_tb,
                            input bit inj_ok, input int wr_j, input int wr_val,
                            input string tag);
        int  de, we, span;
        bit  late, ilate;
        logic [2*NCH-1:0] exp;
        if (prog) begin
            write_reg(ch, 1'b0, d);
            write_reg(ch, 1'b1, w);
        end
        de    = (d == 0) ? 1 : d;
        we    = (w == 0) ? 1 : w;
        late  = !tb[0];
        ilate = !inj_tb[0];
        span  = de + we + 2 + ((inj_j >= 0) ? inj_j + de + we + 4 : 0);
        @(negedge clk);
        trig_i[2*ch +: 2] = tb;
        @(posedge clk);
        for (int j = 0; j <= span; j++) begin
            @(negedge clk);
            trig_i = '0;
            wr_en  = 1'b0;
            exp = '0;
            exp[2*ch +: 2] = exp_pair(j, de, we, late);
            if (inj_ok)
                exp[2*ch +: 2] = exp[2*ch +: 2] | exp_pair(j - inj_j - 1, de, we, ilate);
            check(pulse_o === exp, tag, pulse_o, exp);
            if (j == inj_j) trig_i[2*ch +: 2] = inj_tb;
            if (j == wr_j) begin
                wr_en   = 1'b1;
                wr_addr = ADDR_W'(ch * 2 + 1);
                wr_data = CNT_W'(wr_val);
            end
        end
        @(negedge clk);
        wr_en  = 1'b0;
        trig_i = '0;
    endtask

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: triggers during reset are ignored
        trig_i = '1;
        repeat (4) @(negedge clk);
        check(pulse_o === '0, "R1 during reset", pulse_o, '0);
        trig_i = '0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(pulse_o === '0, "R1 after reset", pulse_o, '0);
        repeat (3) @(negedge clk);
        check(pulse_o === '0, "R1 idle", pulse_o, '0);

        // table walk: R2 R3 R4 R5 R8
        for (int i = 0; i < NVEC; i++)
            run_case(V_CH[i], V_TR[i], V_D[i], V_W[i], 1'b1, -1, 2'b00, 1'b0, -1, 0, vec_tag(i));

        // R6: triggers during delay, last width cycle and tail are ignored
        run_case(0, 2'b01, 4, 3, 1'b1, 1, 2'b10, 1'b0, -1, 0, "R6 busy delay");
        run_case(0, 2'b01, 2, 3, 1'b1, 4, 2'b01, 1'b0, -1, 0, "R6 busy last width");
        run_case(1, 2'b10, 2, 2, 1'b1, 4, 2'b01, 1'b0, -1, 0, "R6 busy tail");
        // R6: rearm in first idle cycle
        run_case(2, 2'b01, 2, 2, 1'b1, 4, 2'b10, 1'b1, -1, 0, "R6 rearm early");
        run_case(3, 2'b10, 1, 2, 1'b1, 4, 2'b01, 1'b1, -1, 0, "R6 rearm late");

        // R7: width write mid-pulse ignored, used by next trigger
        run_case(5, 2'b01, 3, 4, 1'b1, -1, 2'b00, 1'b0, 4, 9, "R7 mid-pulse write");
        run_case(5, 2'b10, 3, 9, 1'b0, -1, 2'b00, 1'b0, -1, 0, "R7 new width applied");

        // R9: full-scale presets
        run_case(6, 2'b10, 8191, 8191, 1'b1, -1, 2'b00, 1'b0, -1, 0, "R9 full scale");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule